// File: doc/BRIEF.md
# Write-Protect and Status Controller

This block sits beside the command engine of a small serial non-volatile memory. It keeps the three pieces of state that govern whether the memory may be changed. The first is a write-enable latch, set and cleared by dedicated commands. The second is a two-bit protection level, which selects how much of the upper address space is locked. The third is the busy indication of the internal write timer, which is passed through to the status byte. The command engine sends decoded, already-completed command strobes to the block. The block answers each pending array write or status write with a same-cycle permit.

The permit is the AND of four conditions: the hardware lock pin is high, the latch is set, no write cycle is running, and (for array writes) the target page lies outside the locked region. A granted write of either kind clears the latch on the next clock edge. A refused write leaves the latch untouched. The protection level is held in flops that only the block reset clears; they stand in for non-volatile bits.

Top module: `nvm_wprot_status`

## Requirements
- R1: `status_byte` reads bits [7:4] as 0, bit 3 and bit 2 as the high and low protection-level bits, bit 1 as the write-enable latch and bit 0 as `cyc_busy` of the same cycle.
- R2: While `rst_n` is low and after it rises, the latch is 0 and the protection level is 00, so `status_byte` is 0x00 when idle.
- R3: A `wen_set` pulse with `lock_n` high sets the latch at the next clock edge, whatever the protection level.
- R4: A `wen_clr` pulse clears the latch at the next edge; if `wen_set` and `wen_clr` arrive together, the clear wins.
- R5: While `lock_n` is low, `wr_grant` is 0 and the latch is cleared at the next edge; a set pulse in that cycle is lost.
- R6: With the latch set, an array write to `arr_addr` is refused when the address falls in the locked range of the level: 00 locks none, 01 locks 0x180–0x1FF, 10 locks 0x100–0x1FF, 11 locks 0x000–0x1FF.
- R7: With the latch clear, neither an array write nor a status write is granted.
- R8: A granted write clears the latch at the next edge; a refused array write leaves the latch set.
- R9: A granted status write loads the protection level from `stat_wr_data[3:2]` at the next edge; the other data bits have no effect on `status_byte`.
- R10: A refused status write leaves the protection level unchanged.
- R11: While `cyc_busy` is 1, no write is granted and the status byte stays readable with bit 0 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| lock_n | input | 1 | Hardware lock pin, low forbids all writes |
| cyc_busy | input | 1 | Internal write cycle in progress |
| wen_set | input | 1 | Completed enable command, one-cycle pulse |
| wen_clr | input | 1 | Completed disable command, one-cycle pulse |
| arr_wr_req | input | 1 | Completed array write awaiting a permit |
| arr_addr | input | ADDR_W | Target address of the array write |
| stat_wr_req | input | 1 | Completed status write awaiting a permit |
| stat_wr_data | input | STAT_W | Byte sent with the status write |
| wr_grant | output | 1 | Permit for the pending request, same cycle |
| status_byte | output | STAT_W | Status byte for the read-status command |
| wen_q | output | 1 | Write-enable latch state |

## Verification
The bench aims at the exact edges of each locked range. It writes 0x17F against 0x180 at level 01, and 0x0FF against 0x100 at level 10. A decoder that is off by one region, or that tests the wrong address bit, grants the wrong one of each pair. The bench also refuses a write and then checks that the latch is still set, to catch a design that clears the latch on any request. It sends status writes with junk in the unused data bits, to show that only the level bits are stored. It drops the lock pin during a busy cycle, to show that the busy bit is kept and the latch is cleared. Last, it pulses both latch commands in one cycle, so a design that gives set the priority is caught.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

   typedef enum logic [1:0] {
      LVL_OPEN    = 2'b00,
      LVL_QUARTER = 2'b01,
      LVL_HALF    = 2'b10,
      LVL_FULL    = 2'b11
   } lock_lvl_e;

   localparam int STAT_WIP  = 0;
   localparam int STAT_WEL  = 1;
   localparam int STAT_BPLO = 2;
   localparam int STAT_BPHI = 3;

endpackage

// File: rtl/wprot_region.sv
module wprot_region
   import wprot_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  lock_lvl_e          lvl,
   input  logic [ADDR_W-1:0]  addr,
   output logic               in_lock
);

   localparam int TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("wprot_region: ADDR_W must be at least 3");
      end
   endgenerate

   always_comb begin
      unique case (lvl)
         LVL_OPEN:    in_lock = 1'b0;
         LVL_QUARTER: in_lock = (addr[TOP -: 2] == 2'b11);
         LVL_HALF:    in_lock = addr[TOP];
         default:     in_lock = 1'b1;
      endcase
   end

endmodule

// File: rtl/wprot_latch.sv
module wprot_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_n,
   input  logic set_stb,
   input  logic clr_stb,
   input  logic wr_done,
   output logic wel_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   wel_q <= 1'b0;
      else if (!lock_n)             wel_q <= 1'b0;
      else if (wr_done || clr_stb)  wel_q <= 1'b0;
      else if (set_stb)             wel_q <= 1'b1;
   end

endmodule

// File: rtl/wprot_lvlreg.sv
module wprot_lvlreg
   import wprot_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  lock_lvl_e din,
   output lock_lvl_e lvl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lvl_q <= LVL_OPEN;
      else if (load)  lvl_q <= din;
   end

endmodule

// File: rtl/nvm_wprot_status.sv
module nvm_wprot_status
   import wprot_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_n,
   input  logic              cyc_busy,
   input  logic              wen_set,
   input  logic              wen_clr,
   input  logic              arr_wr_req,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic              stat_wr_req,
   input  logic [STAT_W-1:0] stat_wr_data,
   output logic              wr_grant,
   output logic [STAT_W-1:0] status_byte,
   output logic              wen_q
);

   localparam int PAD_LO = STAT_BPHI + 1;

   generate
      if (STAT_W < 8) begin : g_bad_stat
         $error("nvm_wprot_status: STAT_W must be at least 8");
      end
   endgenerate

   lock_lvl_e lvl_q;
   logic      in_lock;
   logic      may_write;
   logic      arr_ok;
   logic      stat_ok;
   logic      stat_load;
   logic      unused_data;

   assign unused_data = ^{stat_wr_data[STAT_W-1:PAD_LO], stat_wr_data[STAT_BPLO-1:0]};

   wprot_region #(.ADDR_W(ADDR_W)) i_region (
      .lvl     (lvl_q),
      .addr    (arr_addr),
      .in_lock (in_lock)
   );

   // common gate: pin high, latch set, timer idle
   assign may_write = lock_n & wen_q & ~cyc_busy;
   assign arr_ok    = arr_wr_req & may_write & ~in_lock;
   assign stat_ok   = stat_wr_req & may_write;
   assign wr_grant  = arr_ok | stat_ok;
   assign stat_load = stat_ok;

   wprot_latch i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_n  (lock_n),
      .set_stb (wen_set),
      .clr_stb (wen_clr),
      .wr_done (wr_grant),
      .wel_q   (wen_q)
   );

   wprot_lvlreg i_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (stat_load),
      .din   (lock_lvl_e'(stat_wr_data[STAT_BPHI:STAT_BPLO])),
      .lvl_q (lvl_q)
   );

   generate
      for (genvar b = PAD_LO; b < STAT_W; b++) begin : g_pad
         assign status_byte[b] = 1'b0;
      end
   endgenerate

   assign status_byte[STAT_BPHI:STAT_BPLO] = lvl_q;
   assign status_byte[STAT_WEL]            = wen_q;
   assign status_byte[STAT_WIP]            = cyc_busy;

endmodule

// File: rtl/nvm_wprot_checker.sv
module nvm_wprot_checker #(
   parameter int ADDR_W = 9,
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock_n,
   input logic              cyc_busy,
   input logic              wen_set,
   input logic              wen_clr,
   input logic              arr_wr_req,
   input logic [ADDR_W-1:0] arr_addr,
   input logic              stat_wr_req,
   input logic              wr_grant,
   input logic [STAT_W-1:0] status_byte,
   input logic              wen_q
);

   assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wen_set && lock_n && !wen_clr && !wr_grant) |=> wen_q);

   assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wen_clr |=> !wen_q);

   assert_lock_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_n |=> !status_byte[1]);

   assert_lock_denies_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_n |-> !wr_grant);

   assert_full_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[3:2] == 2'b11 && arr_wr_req && !stat_wr_req) |-> !wr_grant);

   assert_open_lvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[3:2] == 2'b00 && arr_wr_req && wen_q && lock_n && !cyc_busy) |-> wr_grant);

   assert_no_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wen_q |-> !wr_grant);

   assert_grant_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |=> !wen_q);

   assert_lvl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_wr_req && wr_grant) |=> $stable(status_byte[3:2]));

   assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_busy |-> (!wr_grant && status_byte[0]));

   assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[STAT_W-1:4] == '0);

endmodule

bind nvm_wprot_status nvm_wprot_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lock_n      (lock_n),
   .cyc_busy    (cyc_busy),
   .wen_set     (wen_set),
   .wen_clr     (wen_clr),
   .arr_wr_req  (arr_wr_req),
   .arr_addr    (arr_addr),
   .stat_wr_req (stat_wr_req),
   .wr_grant    (wr_grant),
   .status_byte (status_byte),
   .wen_q       (wen_q)
);

// File: tb/test_nvm_wprot_status.sv
module test_nvm_wprot_status;

   localparam int AW = 9;
   localparam int SW = 8;
   localparam int NV = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lock_n = 1'b1;
   logic          cyc_busy = 1'b0;
   logic          wen_set = 1'b0;
   logic          wen_clr = 1'b0;
   logic          arr_wr_req = 1'b0;
   logic [AW-1:0] arr_addr = '0;
   logic          stat_wr_req = 1'b0;
   logic [SW-1:0] stat_wr_data = '0;
   logic          wr_grant;
   logic [SW-1:0] status_byte;
   logic          wen_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   nvm_wprot_status #(.ADDR_W(AW), .STAT_W(SW)) i_nvm_wprot_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .lock_n       (lock_n),
      .cyc_busy     (cyc_busy),
      .wen_set      (wen_set),
      .wen_clr      (wen_clr),
      .arr_wr_req   (arr_wr_req),
      .arr_addr     (arr_addr),
      .stat_wr_req  (stat_wr_req),
      .stat_wr_data (stat_wr_data),
      .wr_grant     (wr_grant),
      .status_byte  (status_byte),
      .wen_q        (wen_q)
   );

   typedef struct packed {
      logic       lk;
      logic       bz;
      logic       st;
      logic       cl;
      logic       aw;
      logic       sw;
      logic [7:0] sd;
      logic [8:0] ad;
      logic       eg;
      logic [7:0] es;
      logic [3:0] rq;
   } vec_t;

   // lk bz st cl aw sw data addr grant status req
   localparam vec_t VEC [NV] = '{
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h02,3},   // R3 set
      '{1,0,0,0,1,0,8'h00,9'h1F0,1,8'h00,8},   // R8 open level, grant clears
      '{1,0,0,0,1,0,8'h00,9'h010,0,8'h00,7},   // R7 no latch
      '{1,0,0,0,0,1,8'hFC,9'h000,0,8'h00,7},   // R7 status write refused
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h02,3},   // R3
      '{1,0,0,0,0,1,8'hF7,9'h000,1,8'h04,9},   // R9 level 01, junk bits ignored
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h06,3},   // R3 set with level 01
      '{1,0,0,0,1,0,8'h00,9'h180,0,8'h06,6},   // R6 quarter edge locked
      '{1,0,0,0,1,0,8'h00,9'h17F,1,8'h04,6},   // R6 just below quarter
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h06,3},   // R3
      '{1,0,0,0,1,0,8'h00,9'h1FF,0,8'h06,8},   // R8 refused keeps latch
      '{1,0,0,0,0,1,8'h08,9'h000,1,8'h08,9},   // R9 level 10
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0A,3},   // R3
      '{1,0,0,0,1,0,8'h00,9'h100,0,8'h0A,6},   // R6 half edge locked
      '{1,0,0,0,1,0,8'h00,9'h0FF,1,8'h08,6},   // R6 just below half
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0A,3},   // R3
      '{1,0,0,1,0,0,8'h00,9'h000,0,8'h08,4},   // R4 clear
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0A,3},   // R3
      '{0,0,0,0,0,0,8'h00,9'h000,0,8'h08,5},   // R5 pin low clears
      '{0,0,1,0,0,0,8'h00,9'h000,0,8'h08,5},   // R5 set lost
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0A,3},   // R3
      '{0,0,0,0,0,1,8'h00,9'h000,0,8'h08,10},  // R10 pin low refuses status write
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0A,3},   // R3
      '{1,0,0,0,0,1,8'h0C,9'h000,1,8'h0C,9},   // R9 level 11
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0E,3},   // R3
      '{1,0,0,0,1,0,8'h00,9'h000,0,8'h0E,6},   // R6 full lock
      '{1,1,0,0,0,1,8'h00,9'h000,0,8'h0F,11},  // R11 busy refuses, WIP shown
      '{0,1,0,0,0,0,8'h00,9'h000,0,8'h0D,11},  // R11 pin low while busy
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h0E,3},   // R3
      '{1,0,0,0,0,1,8'h00,9'h000,1,8'h00,9},   // R9 back to level 00
      '{1,0,1,0,0,0,8'h00,9'h000,0,8'h02,3},   // R3
      '{1,0,0,0,1,0,8'h00,9'h000,1,8'h00,1}    // R1 status layout after grant
   };

   task automatic check(input bit ok, input int rq, input int act, input int exp, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic idle_strobes();
      wen_set = 1'b0; wen_clr = 1'b0; arr_wr_req = 1'b0; stat_wr_req = 1'b0;
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      lock_n = v.lk; cyc_busy = v.bz; wen_set = v.st; wen_clr = v.cl;
      arr_wr_req = v.aw; stat_wr_req = v.sw; stat_wr_data = v.sd; arr_addr = v.ad;
      #1;
      check(wr_grant == v.eg, int'(v.rq), int'(wr_grant), int'(v.eg), "grant");
      @(negedge clk);
      idle_strobes();
      #1;
      check(status_byte == v.es, int'(v.rq), int'(status_byte), int'(v.es), "status");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(status_byte == 8'h00, 2, int'(status_byte), 0, "status in reset");  // R2
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(status_byte == 8'h00 && !wen_q, 2, int'(status_byte), 0, "status after reset");  // R2

      for (int i = 0; i < NV; i++) apply(VEC[i]);

      // R4: simultaneous set and clear, clear wins
      apply('{1,0,1,0,0,0,8'h00,9'h000,0,8'h02,3});
      apply('{1,0,1,1,0,0,8'h00,9'h000,0,8'h00,4});

      // R2: reset mid-run wipes level and latch
      apply('{1,0,1,0,0,0,8'h00,9'h000,0,8'h02,3});
      apply('{1,0,0,0,0,1,8'h08,9'h000,1,8'h08,9});
      apply('{1,0,1,0,0,0,8'h00,9'h000,0,8'h0A,3});
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(status_byte == 8'h00, 2, int'(status_byte), 0, "status under reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(status_byte == 8'h00 && !wen_q, 2, int'(status_byte), 0, "status after second reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule